// File: doc/BRIEF.md
# Snooping Write-Through Coherence Controller

Four processor cores each own a small direct-mapped, write-through cache of single-word lines. All caches share one bus to a common main memory, and every cache controller watches that bus. A core issues word reads and writes on its own request port. It holds `req_valid_i` together with the address, the write flag and the write data until the block raises `req_ready_o`. For a read, the data is on `rsp_rdata_o` in that same cycle.

Read hits complete inside the cache. Read misses, and every write, go through a round-robin arbiter that gives the bus to one transaction at a time. A bus transaction lasts a fixed number of memory cycles. Its memory access, its completion and all snoop actions take effect on one clock edge.

The static input `mode_upd_i` selects the coherence policy:
- **Invalidate mode (0):** a write removes other cached copies. A per-line exclusive flag lets the writer skip that broadcast when no other cache can hold the line.
- **Update mode (1):** every write is broadcast, and other holders overwrite their copy with the new data.

Top module: `coh_top`

## Requirements
- R1: A read whose address hits in the requesting core's cache raises `req_ready_o` in the same cycle the request is presented and returns the cached word.
- R2: A read miss takes the bus, completes MEM_LAT cycles after its grant edge with the word currently in memory, and allocates the line so that an immediate re-read of that address hits.
- R3: Every write goes to memory over the bus. Its `req_ready_o` coincides with `bus_done_o`. A write miss does not allocate, so a following read of that address misses.
- R4: Only one bus transaction is in flight at a time, and at most one core receives a bus completion per cycle. Grants rotate round-robin, so a waiting request completes within (NUM_CORES+1)*(MEM_LAT+1) cycles.
- R5: In invalidate mode (`mode_upd_i`=0), a write that is not to an exclusive line in the writer's cache completes with `bus_snoop_o`=1. Every other copy is then dropped, so another core's next read of that address misses and returns the new value.
- R6: In invalidate mode, once a core's write has left it the only holder, further writes by that core to the line complete with `bus_snoop_o`=0 while still writing memory. This holds until another core reads the address over the bus.
- R7: In update mode (`mode_upd_i`=1), every write, including repeats to the same address, completes with `bus_snoop_o`=1. Other holders overwrite their copy, so their next read of the address hits and returns the new value.
- R8: In both modes, any read that completes after a write has completed on the bus returns that write's value, unless a later write to that address has completed.
- R9: After reset, no cache line is valid, memory holds zero, the bus is idle, and `req_ready_o` stays low while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_upd_i | input | 1 | Static policy select: 0 invalidate, 1 update |
| req_valid_i | input | NUM_CORES | Per-core request valid |
| req_we_i | input | NUM_CORES | Per-core write flag (1 write, 0 read) |
| req_addr_i | input | NUM_CORES x ADDR_W | Per-core word address |
| req_wdata_i | input | NUM_CORES x DATA_W | Per-core write data |
| req_ready_o | output | NUM_CORES | Per-core request completion |
| rsp_rdata_o | output | NUM_CORES x DATA_W | Per-core read data, valid with ready on a read |
| bus_done_o | output | 1 | A bus transaction completes this cycle |
| bus_snoop_o | output | 1 | The completing transaction is a write broadcast to the other caches |

## Verification
A read hit is due in the first sampled cycle after the request is driven. An uncontended bus operation is due MEM_LAT+1 sampled cycles after it is driven: one cycle waiting for the grant edge, then MEM_LAT busy cycles. Directed cases drive one core at a time and compare the exact cycle count against these figures. Random traffic on all four cores only bounds the wait by the round-robin worst case. The bench samples `req_ready_o`, `rsp_rdata_o` and the bus flags half a cycle after each rising edge. It checks every read against its reference memory before applying a write that completes in the same cycle, because that write only lands on the following edge.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic {BUS_IDLE, BUS_BUSY} bus_st_e;
endpackage

// File: rtl/coh_arb.sv
module coh_arb #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [PW-1:0] gnt_idx_o
);
  logic [PW-1:0] ptr_q;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (en_i && req_i[j] && gnt_o == '0) begin
        gnt_o[j]  = 1'b1;
        gnt_idx_o = PW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        ptr_q <= PW'(N - 1);
    else if (|gnt_o)    ptr_q <= gnt_idx_o;
endmodule

// File: rtl/coh_mem.sv
module coh_mem #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/coh_cache.sv
module coh_cache #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  localparam int IW = $clog2(LINES),
  localparam int TW = ADDR_W - IW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_upd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_hit_o,
  output logic [DATA_W-1:0] req_data_o,
  input  logic              bus_done_i,
  input  logic              bus_own_i,
  input  logic              bus_we_i,
  input  logic              bus_snoop_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              snp_excl_o
);
  logic [LINES-1:0]  vld_q, exc_q;
  logic [TW-1:0]     tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IW-1:0] ridx, bidx;
  logic [TW-1:0] rtag, btag;
  logic          bhit;

  assign ridx       = req_addr_i[IW-1:0];
  assign rtag       = req_addr_i[ADDR_W-1:IW];
  assign req_hit_o  = vld_q[ridx] && (tag_q[ridx] == rtag);
  assign req_data_o = dat_q[ridx];

  assign bidx       = bus_addr_i[IW-1:0];
  assign btag       = bus_addr_i[ADDR_W-1:IW];
  assign bhit       = vld_q[bidx] && (tag_q[bidx] == btag);
  assign snp_excl_o = bhit && exc_q[bidx];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      vld_q <= '0;
      exc_q <= '0;
    end else if (bus_done_i) begin
      if (bus_own_i) begin
        if (!bus_we_i) begin
          vld_q[bidx] <= 1'b1;
          exc_q[bidx] <= 1'b0;
        end else if (bhit) begin
          exc_q[bidx] <= !mode_upd_i;  // others were just invalidated
        end
      end else if (bhit) begin
        exc_q[bidx] <= 1'b0;
        if (bus_we_i && bus_snoop_i && !mode_upd_i) vld_q[bidx] <= 1'b0;
      end
    end

  always_ff @(posedge clk_i)
    if (bus_done_i) begin
      if (bus_own_i && !bus_we_i) begin
        tag_q[bidx] <= btag;
        dat_q[bidx] <= bus_rdata_i;
      end else if (bus_we_i && bhit && (bus_own_i || (bus_snoop_i && mode_upd_i))) begin
        dat_q[bidx] <= bus_wdata_i;
      end
    end
endmodule

// File: rtl/coh_top.sv
module coh_top
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LINES     = 4,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int MEM_LAT   = 2,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int LW = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              mode_upd_i,
  input  logic [NUM_CORES-1:0]              req_valid_i,
  input  logic [NUM_CORES-1:0]              req_we_i,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0]  req_addr_i,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]  req_wdata_i,
  output logic [NUM_CORES-1:0]              req_ready_o,
  output logic [NUM_CORES-1:0][DATA_W-1:0]  rsp_rdata_o,
  output logic                              bus_done_o,
  output logic                              bus_snoop_o
);
  bus_st_e           st_q;
  logic [LW-1:0]     cnt_q;
  logic [CW-1:0]     own_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] mem_rdata;
  logic              busy, done, snoop;

  logic [NUM_CORES-1:0]             hit, excl, bus_req, gnt;
  logic [NUM_CORES-1:0][DATA_W-1:0] cdata;
  logic [CW-1:0]                    gidx;

  assign busy  = (st_q == BUS_BUSY);
  assign done  = busy && (cnt_q == '0);
  assign snoop = done && we_q && (mode_upd_i || !excl[own_q]);

  assign bus_req = req_valid_i & (req_we_i | ~hit);

  coh_arb #(.N(NUM_CORES)) i_arb (
    .clk_i, .rst_ni, .en_i(!busy), .req_i(bus_req), .gnt_o(gnt), .gnt_idx_o(gidx)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      cnt_q   <= '0;
      own_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!busy) begin
      if (|gnt) begin
        st_q    <= BUS_BUSY;
        cnt_q   <= LW'(MEM_LAT - 1);
        own_q   <= gidx;
        we_q    <= req_we_i[gidx];
        addr_q  <= req_addr_i[gidx];
        wdata_q <= req_wdata_i[gidx];
      end
    end else if (done) begin
      st_q <= BUS_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end

  coh_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i, .rst_ni, .we_i(done && we_q), .addr_i(addr_q), .wdata_i(wdata_q), .rdata_o(mem_rdata)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic own_done;
    assign own_done = done && (own_q == CW'(c));

    coh_cache #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cache (
      .clk_i, .rst_ni, .mode_upd_i,
      .req_addr_i (req_addr_i[c]),
      .req_hit_o  (hit[c]),
      .req_data_o (cdata[c]),
      .bus_done_i (done),
      .bus_own_i  (own_q == CW'(c)),
      .bus_we_i   (we_q),
      .bus_snoop_i(snoop),
      .bus_addr_i (addr_q),
      .bus_wdata_i(wdata_q),
      .bus_rdata_i(mem_rdata),
      .snp_excl_o (excl[c])
    );

    assign req_ready_o[c] = req_valid_i[c] && ((!req_we_i[c] && hit[c]) || own_done);
    assign rsp_rdata_o[c] = own_done ? mem_rdata : cdata[c];
  end

  assign bus_done_o  = done;
  assign bus_snoop_o = snoop;
endmodule

// File: rtl/coh_chk.sv
module coh_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 5,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 mode_upd_i,
  input logic [NUM_CORES-1:0] req_valid_i,
  input logic [NUM_CORES-1:0] req_we_i,
  input logic [NUM_CORES-1:0] req_ready_o,
  input logic                 bus_done_o,
  input logic                 bus_snoop_o,
  input logic                 busy_i,
  input logic                 we_q_i,
  input logic [CW-1:0]        own_q_i,
  input logic [ADDR_W-1:0]    addr_q_i
);
  p_write_thru_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(req_valid_i & req_we_i & req_ready_o) |-> bus_done_o);

  p_miss_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_done_o |-> req_ready_o[own_q_i]);

  p_one_writer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_valid_i & req_we_i & req_ready_o));

  p_bus_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !bus_done_o |=> busy_i && $stable(addr_q_i));

  p_snoop_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_snoop_o |-> bus_done_o && we_q_i);

  p_upd_bcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_done_o && we_q_i && mode_upd_i |-> bus_snoop_o);

  p_idle_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
endmodule

bind coh_top coh_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) i_coh_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_upd_i(mode_upd_i),
  .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_ready_o(req_ready_o),
  .bus_done_o(bus_done_o), .bus_snoop_o(bus_snoop_o),
  .busy_i(busy), .we_q_i(we_q), .own_q_i(own_q), .addr_q_i(addr_q)
);

// File: tb/test_coh_top.sv
`timescale 1ns/1ps
module test_coh_top;
  localparam int N   = 4;
  localparam int AW  = 5;
  localparam int DW  = 16;
  localparam int LAT = 2;
  localparam int BUS_CYC = LAT + 1;
  localparam int BOUND   = (N + 1) * (LAT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [N-1:0]         valid = '0, we = '0;
  logic [N-1:0][AW-1:0] addr = '0;
  logic [N-1:0][DW-1:0] wd = '0;
  logic [N-1:0]         ready;
  logic [N-1:0][DW-1:0] rdata;
  logic                 bus_done, bus_snoop;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #2.5 clk = ~clk;

  coh_top #(.NUM_CORES(N), .LINES(4), .ADDR_W(AW), .DATA_W(DW), .MEM_LAT(LAT)) i_coh_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_upd_i(mode),
    .req_valid_i(valid), .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wd),
    .req_ready_o(ready), .rsp_rdata_o(rdata), .bus_done_o(bus_done), .bus_snoop_o(bus_snoop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0; valid = '0; mode = m;
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic op(input int c, input bit w, input int a, input int d,
                    output int rd, output int cyc, output bit sn);
    @(posedge clk); #1;
    valid[c] = 1'b1; we[c] = w; addr[c] = AW'(a); wd[c] = DW'(d);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ready[c] && cyc < 50);
    rd = int'(rdata[c]);
    sn = bus_snoop;
    if (w && ready[c]) ref_mem[a] = DW'(d);
    @(posedge clk); #1;
    valid[c] = 1'b0;
  endtask

  task automatic rd_chk(input int c, input int a, input int exp_cyc, input string req);
    int rd, cyc; bit sn;
    op(c, 1'b0, a, 0, rd, cyc, sn);
    chk(cyc == exp_cyc, {req, " read latency"}, cyc, exp_cyc);
    chk(rd == int'(ref_mem[a]), {req, " read data"}, rd, int'(ref_mem[a]));
  endtask

  task automatic wr_chk(input int c, input int a, input int d, input bit exp_sn, input string req);
    int rd, cyc; bit sn;
    op(c, 1'b1, a, d, rd, cyc, sn);
    chk(cyc == BUS_CYC, {req, " write latency"}, cyc, BUS_CYC);
    chk(sn == exp_sn, {req, " snoop flag"}, int'(sn), int'(exp_sn));
  endtask

  task automatic run_random(input int ncyc);
    bit act [N];
    int lat [N];
    for (int c = 0; c < N; c++) begin act[c] = 0; lat[c] = 0; end
    for (int t = 0; t < ncyc + 40; t++) begin
      bit fin [N];
      int nwr;
      int wa;
      logic [DW-1:0] wv;
      nwr = 0; wa = 0; wv = '0;
      @(negedge clk);
      for (int c = 0; c < N; c++) begin
        fin[c] = 0;
        if (act[c]) begin
          lat[c]++;
          if (ready[c]) begin
            if (!we[c])
              chk(rdata[c] == ref_mem[addr[c]], "R8 coherent read", int'(rdata[c]), int'(ref_mem[addr[c]]));
            else begin
              chk(bus_done, "R3 write on bus", int'(bus_done), 1);
              nwr++; wa = int'(addr[c]); wv = wd[c];
            end
            chk(lat[c] <= BOUND, "R4 grant latency", lat[c], BOUND);
            act[c] = 0; fin[c] = 1;
          end else if (lat[c] > BOUND) begin
            chk(0, "R4 starved request", lat[c], BOUND);
            lat[c] = -1000;
          end
        end
      end
      if (nwr > 1) chk(0, "R4 single completion", nwr, 1);
      if (nwr > 0) ref_mem[wa] = wv;
      @(posedge clk); #1;
      for (int c = 0; c < N; c++) begin
        if (fin[c]) valid[c] = 1'b0;
        if (!act[c] && t < ncyc && $urandom_range(0, 3) != 0) begin
          act[c] = 1; lat[c] = 0;
          we[c] = ($urandom_range(0, 2) == 0);
          addr[c] = AW'($urandom_range(0, 11));
          wd[c] = DW'($urandom);
          valid[c] = 1'b1;
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));

    // invalidate mode
    do_reset(1'b0);
    @(negedge clk);
    chk(ready == '0 && !bus_done, "R9 idle after reset", int'(ready), 0);
    rd_chk(0, 5, BUS_CYC, "R9");                // empty cache, memory zero
    rd_chk(0, 5, 1, "R1");                      // allocated by the miss (R2)
    rd_chk(1, 5, BUS_CYC, "R2");
    wr_chk(0, 5, 16'h1111, 1'b1, "R5");
    rd_chk(1, 5, BUS_CYC, "R5");                // copy was dropped
    rd_chk(0, 5, 1, "R1");
    wr_chk(0, 5, 16'h2222, 1'b1, "R6");          // core1 re-fetched, broadcast again
    wr_chk(0, 5, 16'h3333, 1'b0, "R6");          // now exclusive
    wr_chk(0, 5, 16'h4444, 1'b0, "R6");
    rd_chk(1, 5, BUS_CYC, "R6");
    wr_chk(2, 9, 16'h5555, 1'b1, "R3");          // write miss
    rd_chk(2, 9, BUS_CYC, "R3");                // not allocated by the write
    rd_chk(2, 9, 1, "R2");
    run_random(2500);

    // update mode
    do_reset(1'b1);
    @(negedge clk);
    chk(ready == '0 && !bus_done, "R9 idle after reset", int'(ready), 0);
    rd_chk(0, 5, BUS_CYC, "R2");
    rd_chk(1, 5, BUS_CYC, "R2");
    wr_chk(0, 5, 16'hAAAA, 1'b1, "R7");
    wr_chk(0, 5, 16'hBBBB, 1'b1, "R7");          // repeat still broadcast
    rd_chk(1, 5, 1, "R7");                      // updated in place
    rd_chk(0, 5, 1, "R7");
    wr_chk(3, 13, 16'hCCCC, 1'b1, "R7");         // conflicts with index of 5
    rd_chk(1, 5, 1, "R7");
    rd_chk(3, 13, BUS_CYC, "R3");
    run_random(2500);

    finish_run();
  end
endmodule